// File: doc/BRIEF.md
# Capture-Ordering Square Selector

This block picks one square out of a 64-square board for a capture-ordered move generator. Every square presents six one-hot piece-class flags, produced elsewhere by attack propagation. The block masks out the squares that are disabled, finds the highest-ranked class present anywhere on the board, and then encodes one square within that class. The result is a 6-bit square index or a "no square" indication.

A mode bit sets the meaning of the ranking. In victim mode the block returns the most valuable attacked target. In aggressor mode the ranking of the five piece classes is reversed, so the block returns the cheapest attacker. Victim mode also produces a board-wide check flag: the OR of a per-square king-attacked flag, which shows that the previous move left a king en prise.

A search controller works through all moves with this block. It pulses start, reads the result one clock later when done is high, sets the chosen square in the disable mask, and pulses start again.

Top module: `mvv_lva_select`

## Requirements
- R1: Flag bit `s*6+c` of `flags_i` is class `c` of square `s`. Square index is rank*8+file. The class codes are: 0 pawn, 1 knight, 2 bishop, 3 rook, 4 queen, 5 sixth class. The sixth class is an empty target in victim mode and the king in aggressor mode. A lone enabled flag is always selected.
- R2: With `mode_i`=0 (victim), classes rank from highest to lowest as queen, rook, bishop, knight, pawn, sixth.
- R3: With `mode_i`=1 (aggressor), classes rank from highest to lowest as pawn, knight, bishop, rook, queen, sixth.
- R4: A square whose `dis_i` bit is 1 is never selected, and its flags have no effect on the result.
- R5: When no enabled square has a flag set, `none_o` is 1 and `sq_o` is 0. Otherwise `none_o` is 0.
- R6: Among enabled squares carrying the winning class, the lowest index wins.
- R7: In victim mode, `check_o` is the OR of all 64 `katk_i` bits, regardless of `dis_i`. In aggressor mode it is 0.
- R8: Inputs are sampled on the clock edge where `start_i` is 1. `done_o` is 1 for exactly the following cycle, and the results are valid in that cycle.
- R9: `sq_o`, `none_o` and `check_o` hold their values until the next start, whatever the inputs do in between.
- R10: After synchronous reset, `sq_o`, `none_o`, `check_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Sample inputs and select |
| mode_i | input | 1 | 0 victim, 1 aggressor |
| flags_i | input | 384 | Six class flags per square |
| dis_i | input | 64 | Per-square disable mask |
| katk_i | input | 64 | Per-square king-attacked flag |
| sq_o | output | 6 | Selected square index |
| none_o | output | 1 | No enabled flagged square |
| check_o | output | 1 | Any king attacked (victim mode) |
| done_o | output | 1 | Result valid pulse |

## Verification
The bench places single flags on every square in every class and both modes, with and without the square disabled. A design that dropped the mask, or used the wrong bit position, would then return the wrong square or miss "no square". Pairs of distinct classes are placed so that the preferred one sits on the higher index. A design that skipped the reversal in one mode, or ranked the sixth class wrongly, would return the lower square instead. Same-class ties catch an encoder that favours the highest index. A case with only king-attacked flags and a fully disabled board catches a check flag that is masked by the disable mask or left active in aggressor mode.

// File: rtl/mvv_pkg.sv
package mvv_pkg;

  typedef enum logic [2:0] {
    CLS_PAWN   = 3'd0,
    CLS_KNIGHT = 3'd1,
    CLS_BISHOP = 3'd2,
    CLS_ROOK   = 3'd3,
    CLS_QUEEN  = 3'd4,
    CLS_SIXTH  = 3'd5
  } cls_e;

  typedef enum logic {
    MODE_VICTIM = 1'b0,
    MODE_AGGR   = 1'b1
  } mode_e;

  // Class that sits at rank position p (0 = best) for a given mode.
  // Aggressor: identity. Victim: piece classes reversed, last class kept last.
  function automatic int rank_to_class(input logic aggr, input int p, input int ncls);
    if (aggr)            return p;
    else if (p == ncls-1) return ncls - 1;
    else                 return ncls - 2 - p;
  endfunction

endpackage

// File: rtl/mvv_class_scan.sv
module mvv_class_scan #(
  parameter int NSQ  = 64,
  parameter int NCLS = 6
) (
  input  logic [NSQ*NCLS-1:0]       flags_i,
  input  logic [NSQ-1:0]            dis_i,
  output logic [NCLS-1:0][NSQ-1:0]  cls_vec_o,
  output logic [NCLS-1:0]           cls_any_o
);

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    for (genvar s = 0; s < NSQ; s++) begin : g_sq
      assign cls_vec_o[c][s] = flags_i[s*NCLS + c] & ~dis_i[s];
    end
    assign cls_any_o[c] = |cls_vec_o[c];
  end

endmodule

// File: rtl/mvv_class_pick.sv
module mvv_class_pick
  import mvv_pkg::*;
#(
  parameter int NCLS = 6,
  localparam int CW  = $clog2(NCLS)
) (
  input  logic [NCLS-1:0] cls_any_i,
  input  logic            aggr_i,
  output logic [CW-1:0]   cls_sel_o,
  output logic            hit_o
);

  always_comb begin
    hit_o     = 1'b0;
    cls_sel_o = '0;
    for (int p = NCLS - 1; p >= 0; p--) begin
      int c;
      c = rank_to_class(aggr_i, p, NCLS);
      if (cls_any_i[c]) begin
        hit_o     = 1'b1;
        cls_sel_o = CW'(c);
      end
    end
  end

endmodule

// File: rtl/mvv_sq_encode.sv
module mvv_sq_encode #(
  parameter int N  = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);

  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o   = IW'(i);
        valid_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mvv_lva_select.sv
module mvv_lva_select
  import mvv_pkg::*;
#(
  parameter int NSQ  = 64,
  parameter int NCLS = 6,
  localparam int IW  = $clog2(NSQ),
  localparam int CW  = $clog2(NCLS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 mode_i,
  input  logic [NSQ*NCLS-1:0]  flags_i,
  input  logic [NSQ-1:0]       dis_i,
  input  logic [NSQ-1:0]       katk_i,
  output logic [IW-1:0]        sq_o,
  output logic                 none_o,
  output logic                 check_o,
  output logic                 done_o
);

  logic [NCLS-1:0][NSQ-1:0] cls_vec;
  logic [NCLS-1:0]          cls_any;
  logic [CW-1:0]            cls_sel;
  logic                     cls_hit;
  logic [NSQ-1:0]           win_vec;
  logic [IW-1:0]            win_idx;
  logic                     win_valid;

  // Level 1: mask and reduce per class
  mvv_class_scan #(.NSQ(NSQ), .NCLS(NCLS)) u_scan (
    .flags_i   (flags_i),
    .dis_i     (dis_i),
    .cls_vec_o (cls_vec),
    .cls_any_o (cls_any)
  );

  // Choose best class present for the current mode
  mvv_class_pick #(.NCLS(NCLS)) u_pick (
    .cls_any_i (cls_any),
    .aggr_i    (mode_i == MODE_AGGR),
    .cls_sel_o (cls_sel),
    .hit_o     (cls_hit)
  );

  assign win_vec = cls_vec[cls_sel];

  // Level 2: lowest square inside the winning class
  mvv_sq_encode #(.N(NSQ)) u_enc (
    .vec_i   (win_vec),
    .idx_o   (win_idx),
    .valid_o (win_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_o    <= '0;
      none_o  <= 1'b0;
      check_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        sq_o    <= (cls_hit && win_valid) ? win_idx : '0;
        none_o  <= ~cls_hit;
        check_o <= (mode_i == MODE_VICTIM) && (|katk_i);
      end
    end
  end

endmodule

// File: rtl/mvv_lva_select_chk.sv
module mvv_lva_select_chk #(
  parameter int NSQ  = 64,
  parameter int NCLS = 6,
  localparam int IW  = $clog2(NSQ)
) (
  input logic                clk,
  input logic                rst,
  input logic                start_i,
  input logic                mode_i,
  input logic [NSQ*NCLS-1:0] flags_i,
  input logic [NSQ-1:0]      dis_i,
  input logic [IW-1:0]       sq_o,
  input logic                none_o,
  input logic                check_o,
  input logic                done_o
);

  logic [NSQ*NCLS-1:0] cap_flags;
  logic [NSQ-1:0]      cap_dis;
  logic                cap_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_flags <= '0;
      cap_dis   <= '0;
      cap_mode  <= 1'b0;
    end else if (start_i) begin
      cap_flags <= flags_i;
      cap_dis   <= dis_i;
      cap_mode  <= mode_i;
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start_i |=> done_o); // R8
  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(start_i)); // R8
  AST_NONE_SQ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done_o && none_o) |-> (sq_o == '0)); // R5
  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (done_o && !none_o) |-> !cap_dis[sq_o]); // R4
  AST_WIN_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (done_o && !none_o) |-> (|cap_flags[sq_o*NCLS +: NCLS])); // R1
  AST_AGGR_NO_CHECK: assert property (@(posedge clk) disable iff (rst)
    (done_o && cap_mode) |-> !check_o); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !$past(start_i) |-> ($stable(sq_o) && $stable(none_o) && $stable(check_o))); // R9

endmodule

bind mvv_lva_select mvv_lva_select_chk #(.NSQ(NSQ), .NCLS(NCLS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .mode_i    (mode_i),
  .flags_i   (flags_i),
  .dis_i     (dis_i),
  .sq_o      (sq_o),
  .none_o    (none_o),
  .check_o   (check_o),
  .done_o    (done_o)
);

// File: tb/sim_mvv_lva_select.sv
`timescale 1ns/1ps
module sim_mvv_lva_select;

  localparam int NSQ  = 64;
  localparam int NCLS = 6;
  localparam int FW   = NSQ*NCLS;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic            mode = 1'b0;
  logic [FW-1:0]   flags = '0;
  logic [NSQ-1:0]  dis = '0;
  logic [NSQ-1:0]  katk = '0;
  logic [5:0]      sq;
  logic            none, chk, done;

  int nchecks = 0;
  int nerrors = 0;
  bit finished = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  mvv_lva_select u0 (
    .clk(clk), .rst(rst), .start_i(start), .mode_i(mode),
    .flags_i(flags), .dis_i(dis), .katk_i(katk),
    .sq_o(sq), .none_o(none), .check_o(chk), .done_o(done)
  );

  function automatic logic [31:0] next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  // Reference model straight from R1..R7
  task automatic model(input logic [FW-1:0] f, input logic [NSQ-1:0] d, k,
                       input logic m, output logic [5:0] esq,
                       output logic enone, output logic echk);
    int vic_order [6] = '{4, 3, 2, 1, 0, 5};
    int agg_order [6] = '{0, 1, 2, 3, 4, 5};
    bit found = 0;
    esq = 0;
    for (int p = 0; p < 6 && !found; p++) begin
      int c = m ? agg_order[p] : vic_order[p];
      for (int s = 0; s < NSQ && !found; s++)
        if (!d[s] && f[s*NCLS + c]) begin
          found = 1;
          esq = 6'(s);
        end
    end
    enone = !found;
    echk  = !m && (|k);
  endtask

  task automatic apply(input logic [FW-1:0] f, input logic [NSQ-1:0] d, k,
                       input logic m);
    @(negedge clk);
    flags = f; dis = d; katk = k; mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic compare(input string tag, input logic [5:0] esq,
                         input logic enone, input logic echk);
    nchecks++;
    if (done !== 1'b1 || sq !== esq || none !== enone || chk !== echk) begin
      nerrors++;
      $display("FAIL %s: got done=%b sq=%0d none=%b check=%b, expected done=1 sq=%0d none=%b check=%b",
               tag, done, sq, none, chk, esq, enone, echk);
    end
  endtask

  task automatic run_model(input string tag, input logic [FW-1:0] f,
                           input logic [NSQ-1:0] d, k, input logic m);
    logic [5:0] esq; logic enone, echk;
    model(f, d, k, m, esq, enone, echk);
    apply(f, d, k, m);
    compare(tag, esq, enone, echk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerrors++; nchecks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", nerrors, nchecks);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] f;
    logic [NSQ-1:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    nchecks++;
    if (sq !== 0 || none !== 0 || chk !== 0 || done !== 0) begin
      nerrors++;
      $display("FAIL R10: got sq=%0d none=%b check=%b done=%b, expected all 0",
               sq, none, chk, done);
    end

    // R1 / R4 / R5: every lone flag, enabled then disabled
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < NSQ; s++)
        for (int c = 0; c < NCLS; c++) begin
          f = '0; f[s*NCLS + c] = 1'b1;
          apply(f, '0, '0, m[0]);
          compare("R1", 6'(s), 1'b0, 1'b0);
          d = '0; d[s] = 1'b1;
          apply(f, d, '0, m[0]);
          compare("R4", 6'd0, 1'b1, 1'b0);
        end

    // R2 / R3: class pairs, lower-ranked class on lower square
    for (int m = 0; m < 2; m++)
      for (int ca = 0; ca < NCLS; ca++)
        for (int cb = 0; cb < NCLS; cb++)
          if (ca != cb) begin
            f = '0;
            f[3*NCLS + ca]  = 1'b1;
            f[50*NCLS + cb] = 1'b1;
            run_model(m ? "R3" : "R2", f, '0, '0, m[0]);
          end

    // R6: same-class ties pick lowest index
    for (int c = 0; c < NCLS; c++)
      for (int i = 0; i < 8; i++) begin
        int a = int'(next_rand() % 32);
        int b = 32 + int'(next_rand() % 32);
        f = '0; f[a*NCLS + c] = 1'b1; f[b*NCLS + c] = 1'b1;
        apply(f, '0, '0, 1'b0);
        compare("R6", 6'(a), 1'b0, 1'b0);
      end

    // R5: empty board
    apply('0, '0, '0, 1'b0);
    compare("R5", 6'd0, 1'b1, 1'b0);

    // R7: check ignores disable mask, suppressed in aggressor mode
    apply('0, '1, 64'h0000_8000_0000_0000, 1'b0);
    compare("R7", 6'd0, 1'b1, 1'b1);
    apply('0, '0, 64'h1, 1'b1);
    compare("R7", 6'd0, 1'b1, 1'b0);

    // R2 / R3 / R4: random boards
    for (int t = 0; t < 1500; t++) begin
      logic [NSQ-1:0] k;
      f = '0;
      for (int s = 0; s < NSQ; s++) begin
        logic [31:0] r = next_rand();
        if (r[7:4] < 4'd3) f[s*NCLS + int'(r[3:0] % 6)] = 1'b1;
      end
      d = {next_rand(), next_rand()} & {next_rand(), next_rand()};
      k = (t % 3 == 0) ? ({32'h0, next_rand()} & 64'h1) : '0;
      run_model((t % 2) ? "R3" : "R2", f, d, k, t[0]);
    end

    // R8 / R9: result held and done low while inputs change without start
    f = '0; f[20*NCLS + 4] = 1'b1;
    apply(f, '0, 64'h4, 1'b0);
    compare("R8", 6'd20, 1'b0, 1'b1);
    @(negedge clk);
    flags = '0; dis = '1; katk = '0; mode = 1'b1;
    repeat (3) @(negedge clk);
    nchecks++;
    if (done !== 1'b0 || sq !== 6'd20 || none !== 1'b0 || chk !== 1'b1) begin
      nerrors++;
      $display("FAIL R9: got done=%b sq=%0d none=%b check=%b, expected done=0 sq=20 none=0 check=1",
               done, sq, none, chk);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerrors, nchecks);
    $finish;
  end

endmodule